// File: doc/BRIEF.md
# Dual-Clock Timer Counter with Coherent Halfword Reads

The block holds a 32-bit up-counter that runs in a timer clock domain, controlled by a host bus that runs on a separate clock with no fixed phase or frequency relation to it. The host sets a start bit and an auto-reload bit, writes a reload value, and can force a reload through a trigger offset. It reads and writes the counter either as one 32-bit word or as two 16-bit halves. A 16-bit read of the low half also captures the high half of the same sample into a holding register. The following read of the high half returns that held value, so a narrow host still sees a single consistent count.

In the timer domain the counter takes its next value from four sources, in fixed priority. A host write comes first, then a reload, then the zero clear after an overflow in one-shot mode, then the increment. Host writes pass into the timer domain through a shadow register and a toggle handshake, and a busy output covers that transfer. The counter, the load value and the control bits come back to the bus domain through a continuously repeated snapshot handshake. Every bus read is therefore a whole, settled sample of the counter.

Top module: `split_read_timer`

## Requirements
- R1: After reset the counter, the load value and both control bits read as zero, `wr_busy` and `ovf_pulse` are low, and a high-half read returns zero.
- R2: A 32-bit read at offset 0x0 (`bus_half`=0) returns a settled sample of the counter. `bus_rdata` carries it in the cycle after `bus_rd`, and `bus_rvalid` marks that cycle.
- R3: A 16-bit read at offset 0x0 (`bus_half`=1) returns the low 16 bits of the sample in `bus_rdata[15:0]`, with the upper bits zero. It also stores the high 16 bits of the same sample in the holding register.
- R4: A 16-bit read at offset 0x2 returns the holding register, not the live upper bits of the counter. Reading low then high yields one coherent 32-bit value.
- R5: A host write to the counter takes priority over reload, clear and increment. Offset 0x0 with `bus_half`=0 writes all 32 bits. With `bus_half`=1, offset 0x0 replaces only the low half and offset 0x2 replaces only the high half, each taking its data from `bus_wdata[15:0]`.
- R6: Offset 0x4 holds the load value. Any write to offset 0xC copies the load value into the counter. An overflow while auto-reload is set also copies it.
- R7: Offset 0x8 holds the control bits: bit 0 is start and bit 1 is auto-reload. With auto-reload clear, an overflow sets the counter to zero and clears start. A reload in the same cycle beats that clear.
- R8: While start is set the counter increments by one every timer clock. While start is clear it holds its value.
- R9: An overflow is the counter leaving 0xFFFFFFFF while start is set and no host counter write applies in that cycle. Each overflow raises `ovf_pulse` for exactly one timer clock.
- R10: `wr_busy` rises in the cycle after an accepted write and stays high until the timer domain has applied it. A write issued while `wr_busy` is high is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bus_clk | input | 1 | Host bus clock |
| bus_rst | input | 1 | Synchronous active-high reset, bus domain |
| bus_wr | input | 1 | Write strobe, one bus cycle |
| bus_rd | input | 1 | Read strobe, one bus cycle |
| bus_half | input | 1 | 1 selects a 16-bit access, 0 a 32-bit access |
| bus_addr | input | 4 | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| bus_rvalid | output | 1 | Read data valid, one cycle after `bus_rd` |
| wr_busy | output | 1 | A host write is still crossing to the timer domain |
| tmr_clk | input | 1 | Timer clock, asynchronous to `bus_clk` |
| tmr_rst | input | 1 | Synchronous active-high reset, timer domain |
| ovf_pulse | output | 1 | One-timer-cycle overflow indication |

## Verification
The risky coincidence is a trigger-driven reload landing in the same timer cycle as a one-shot overflow: the priority must keep the reload and still clear start. The bench provokes this with a sweep. It arms a one-shot run a few counts below the maximum, then issues the trigger after a delay that grows by one bus cycle per pass, so the apply point walks across the overflow cycle. Each outcome is judged at the ports. Either the counter is still running above the load value with no pulse, or it is stopped exactly at the load value after one pulse. A stopped counter at zero shows that the clear beat the reload.

// File: rtl/srt_pkg.sv
package srt_pkg;

  // What a shadowed host write does once it reaches the timer domain
  typedef enum logic [2:0] {
    WK_NONE,
    WK_CNT_ALL,
    WK_CNT_LO,
    WK_CNT_HI,
    WK_LOAD,
    WK_CTRL,
    WK_TRIG
  } wr_kind_t;

  // Byte offsets of the host view; the two counter halves must stay two apart
  localparam int OFS_CNT_LO = 0;
  localparam int OFS_CNT_HI = 2;
  localparam int OFS_LOAD   = 4;
  localparam int OFS_CTRL   = 8;
  localparam int OFS_TRIG   = 12;

  localparam int CTRL_W = 2;

endpackage

// File: rtl/srt_sync.sv
module srt_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '0;
    else     chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];

endmodule

// File: rtl/srt_bus_side.sv
module srt_bus_side
  import srt_pkg::*;
#(
  parameter int CNT_W       = 32,
  parameter int ADDR_W      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr,
  input  logic               rd,
  input  logic               half,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [CNT_W-1:0]   wdata,
  output logic [CNT_W-1:0]   rdata,
  output logic               rvalid,
  output logic               busy,
  output wr_kind_t           sh_kind,
  output logic [CNT_W-1:0]   sh_data,
  output logic               wreq_t,
  input  logic               wack_t,
  output logic               sreq_t,
  input  logic               sack_t,
  input  logic [CNT_W-1:0]   snap_cnt,
  input  logic [CNT_W-1:0]   snap_load,
  input  logic [CTRL_W-1:0]  snap_ctrl,
  output logic [CNT_W/2-1:0] latch_hi
);

  localparam int HALF_W = CNT_W / 2;
  localparam logic [ADDR_W-1:0] A_LO   = ADDR_W'(OFS_CNT_LO);
  localparam logic [ADDR_W-1:0] A_HI   = ADDR_W'(OFS_CNT_HI);
  localparam logic [ADDR_W-1:0] A_LOAD = ADDR_W'(OFS_LOAD);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(OFS_CTRL);
  localparam logic [ADDR_W-1:0] A_TRIG = ADDR_W'(OFS_TRIG);

  logic              wack_s, sack_s;
  wr_kind_t          dec_kind;
  logic              accept;
  logic [CNT_W-1:0]  mir_cnt, mir_load;
  logic [CTRL_W-1:0] mir_ctrl;

  srt_sync #(.STAGES(SYNC_STAGES)) u_wack_sync (.clk(clk), .rst(rst), .d(wack_t), .q(wack_s));
  srt_sync #(.STAGES(SYNC_STAGES)) u_sack_sync (.clk(clk), .rst(rst), .d(sack_t), .q(sack_s));

  always_comb begin
    dec_kind = WK_NONE;
    if (addr == A_LO)              dec_kind = half ? WK_CNT_LO : WK_CNT_ALL;
    else if (addr == A_HI && half) dec_kind = WK_CNT_HI;
    else if (addr == A_LOAD)       dec_kind = WK_LOAD;
    else if (addr == A_CTRL)       dec_kind = WK_CTRL;
    else if (addr == A_TRIG)       dec_kind = WK_TRIG;
  end

  assign accept = wr && !busy && (dec_kind != WK_NONE);

  // Write shadow and toggle request; held still until the acknowledge returns
  always_ff @(posedge clk) begin
    if (rst) begin
      sh_kind <= WK_NONE;
      sh_data <= '0;
      wreq_t  <= 1'b0;
      busy    <= 1'b0;
    end else if (accept) begin
      sh_kind <= dec_kind;
      sh_data <= wdata;
      wreq_t  <= ~wreq_t;
      busy    <= 1'b1;
    end else if (wack_s == wreq_t) begin
      busy    <= 1'b0;
    end
  end

  // Snapshot loop: take the returned sample, then ask for the next one
  always_ff @(posedge clk) begin
    if (rst) begin
      mir_cnt  <= '0;
      mir_load <= '0;
      mir_ctrl <= '0;
      sreq_t   <= 1'b0;
    end else if (sack_s == sreq_t) begin
      mir_cnt  <= snap_cnt;
      mir_load <= snap_load;
      mir_ctrl <= snap_ctrl;
      sreq_t   <= ~sreq_t;
    end
  end

  // Registered read port with the halfword holding register
  always_ff @(posedge clk) begin
    if (rst) begin
      rdata    <= '0;
      rvalid   <= 1'b0;
      latch_hi <= '0;
    end else begin
      rvalid <= rd;
      if (rd) begin
        rdata <= '0;
        if (addr == A_LO) begin
          if (half) begin
            rdata[HALF_W-1:0] <= mir_cnt[HALF_W-1:0];
            latch_hi          <= mir_cnt[CNT_W-1:HALF_W];
          end else begin
            rdata <= mir_cnt;
          end
        end else if (addr == A_HI && half) begin
          rdata[HALF_W-1:0] <= latch_hi;
        end else if (addr == A_LOAD) begin
          rdata <= mir_load;
        end else if (addr == A_CTRL) begin
          rdata <= CNT_W'(mir_ctrl);
        end
      end
    end
  end

endmodule

// File: rtl/srt_tmr_core.sv
module srt_tmr_core
  import srt_pkg::*;
#(
  parameter int CNT_W       = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  wr_kind_t          sh_kind,
  input  logic [CNT_W-1:0]  sh_data,
  input  logic              wreq_t,
  output logic              wack_t,
  input  logic              sreq_t,
  output logic              sack_t,
  output logic [CNT_W-1:0]  snap_cnt,
  output logic [CNT_W-1:0]  snap_load,
  output logic [CTRL_W-1:0] snap_ctrl,
  output logic              ovf_pulse,
  output logic [CNT_W-1:0]  cnt,
  output logic [CNT_W-1:0]  load,
  output logic              run,
  output logic              autorl,
  output logic              apply
);

  localparam int HALF_W = CNT_W / 2;
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic             wreq_s, wreq_d, sreq_s;
  logic             host_cnt, trig, ovf, reload, clr;
  logic [CNT_W-1:0] wval, cnt_nxt;

  srt_sync #(.STAGES(SYNC_STAGES)) u_wreq_sync (.clk(clk), .rst(rst), .d(wreq_t), .q(wreq_s));
  srt_sync #(.STAGES(SYNC_STAGES)) u_sreq_sync (.clk(clk), .rst(rst), .d(sreq_t), .q(sreq_s));

  assign apply  = wreq_s ^ wreq_d;
  assign wack_t = wreq_d;

  always_comb begin
    host_cnt = 1'b0;
    wval     = cnt;
    if (apply) begin
      case (sh_kind)
        WK_CNT_ALL: begin host_cnt = 1'b1; wval = sh_data; end
        WK_CNT_LO:  begin host_cnt = 1'b1; wval = {cnt[CNT_W-1:HALF_W], sh_data[HALF_W-1:0]}; end
        WK_CNT_HI:  begin host_cnt = 1'b1; wval = {sh_data[HALF_W-1:0], cnt[HALF_W-1:0]}; end
        default:    ;
      endcase
    end
  end

  assign trig   = apply && (sh_kind == WK_TRIG);
  assign ovf    = run && (cnt == CNT_MAX) && !host_cnt;
  assign reload = trig || (ovf && autorl);
  assign clr    = ovf && !autorl;

  // Fixed priority: host write, reload, one-shot clear, increment
  always_comb begin
    if (host_cnt)    cnt_nxt = wval;
    else if (reload) cnt_nxt = load;
    else if (clr)    cnt_nxt = '0;
    else if (run)    cnt_nxt = cnt + 1'b1;
    else             cnt_nxt = cnt;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt       <= '0;
      load      <= '0;
      run       <= 1'b0;
      autorl    <= 1'b0;
      ovf_pulse <= 1'b0;
      wreq_d    <= 1'b0;
    end else begin
      cnt       <= cnt_nxt;
      ovf_pulse <= ovf;
      wreq_d    <= wreq_s;
      if (apply && sh_kind == WK_LOAD) load <= sh_data;
      if (apply && sh_kind == WK_CTRL) begin
        run    <= sh_data[0];
        autorl <= sh_data[1];
      end else if (clr) begin
        run <= 1'b0;
      end
    end
  end

  // Snapshot capture on each new request, then acknowledge
  always_ff @(posedge clk) begin
    if (rst) begin
      snap_cnt  <= '0;
      snap_load <= '0;
      snap_ctrl <= '0;
      sack_t    <= 1'b0;
    end else if (sreq_s != sack_t) begin
      snap_cnt  <= cnt;
      snap_load <= load;
      snap_ctrl <= {autorl, run};
      sack_t    <= sreq_s;
    end
  end

endmodule

// File: rtl/split_read_timer.sv
module split_read_timer
  import srt_pkg::*;
#(
  parameter int CNT_W       = 32,
  parameter int ADDR_W      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              bus_clk,
  input  logic              bus_rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic              bus_half,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [CNT_W-1:0]  bus_wdata,
  output logic [CNT_W-1:0]  bus_rdata,
  output logic              bus_rvalid,
  output logic              wr_busy,
  input  logic              tmr_clk,
  input  logic              tmr_rst,
  output logic              ovf_pulse
);

  localparam int HALF_W = CNT_W / 2;

  wr_kind_t          sh_kind;
  logic [CNT_W-1:0]  sh_data;
  logic              wreq_t, wack_t, sreq_t, sack_t;
  logic [CNT_W-1:0]  snap_cnt, snap_load;
  logic [CTRL_W-1:0] snap_ctrl;
  logic [HALF_W-1:0] latch_hi;
  logic [CNT_W-1:0]  t_cnt, t_load;
  logic              t_run, t_autorl, t_apply;

  srt_bus_side #(.CNT_W(CNT_W), .ADDR_W(ADDR_W), .SYNC_STAGES(SYNC_STAGES)) u_bus (
    .clk(bus_clk), .rst(bus_rst), .wr(bus_wr), .rd(bus_rd), .half(bus_half),
    .addr(bus_addr), .wdata(bus_wdata), .rdata(bus_rdata), .rvalid(bus_rvalid),
    .busy(wr_busy), .sh_kind(sh_kind), .sh_data(sh_data), .wreq_t(wreq_t),
    .wack_t(wack_t), .sreq_t(sreq_t), .sack_t(sack_t), .snap_cnt(snap_cnt),
    .snap_load(snap_load), .snap_ctrl(snap_ctrl), .latch_hi(latch_hi)
  );

  srt_tmr_core #(.CNT_W(CNT_W), .SYNC_STAGES(SYNC_STAGES)) u_tmr (
    .clk(tmr_clk), .rst(tmr_rst), .sh_kind(sh_kind), .sh_data(sh_data),
    .wreq_t(wreq_t), .wack_t(wack_t), .sreq_t(sreq_t), .sack_t(sack_t),
    .snap_cnt(snap_cnt), .snap_load(snap_load), .snap_ctrl(snap_ctrl),
    .ovf_pulse(ovf_pulse), .cnt(t_cnt), .load(t_load), .run(t_run),
    .autorl(t_autorl), .apply(t_apply)
  );

endmodule

// File: rtl/split_read_timer_chk.sv
module split_read_timer_chk
  import srt_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int ADDR_W = 4
) (
  input logic               bus_clk,
  input logic               bus_rst,
  input logic               tmr_clk,
  input logic               tmr_rst,
  input logic               bus_rd,
  input logic               bus_half,
  input logic [ADDR_W-1:0]  bus_addr,
  input logic [CNT_W-1:0]   bus_rdata,
  input logic               wr_busy,
  input logic [CNT_W-1:0]   sh_data,
  input logic [CNT_W/2-1:0] latch_hi,
  input wr_kind_t           sh_kind,
  input logic [CNT_W-1:0]   cnt,
  input logic [CNT_W-1:0]   load,
  input logic               run,
  input logic               autorl,
  input logic               apply,
  input logic               ovf_pulse
);

  localparam logic [CNT_W-1:0]  CNT_MAX = {CNT_W{1'b1}};
  localparam logic [ADDR_W-1:0] A_HI    = ADDR_W'(OFS_CNT_HI);

  // R4
  hi_read_from_latch_chk: assert property (@(posedge bus_clk) disable iff (bus_rst)
    (bus_rd && bus_half && bus_addr == A_HI) |=> (bus_rdata == CNT_W'($past(latch_hi))));

  // R10
  shadow_held_while_busy_chk: assert property (@(posedge bus_clk) disable iff (bus_rst)
    wr_busy |=> $stable(sh_data));

  // R5
  host_write_wins_chk: assert property (@(posedge tmr_clk) disable iff (tmr_rst)
    (apply && sh_kind == WK_CNT_ALL) |=> (cnt == $past(sh_data)));

  // R6
  trigger_reload_chk: assert property (@(posedge tmr_clk) disable iff (tmr_rst)
    (apply && sh_kind == WK_TRIG) |=> (cnt == $past(load)));

  // R7
  one_shot_clear_chk: assert property (@(posedge tmr_clk) disable iff (tmr_rst)
    (run && !autorl && cnt == CNT_MAX && !apply) |=> (cnt == '0 && !run));

  // R8
  increment_step_chk: assert property (@(posedge tmr_clk) disable iff (tmr_rst)
    (run && !apply && cnt != CNT_MAX) |=> (cnt == $past(cnt) + 1'b1));

  // R9
  pulse_after_max_chk: assert property (@(posedge tmr_clk) disable iff (tmr_rst)
    ovf_pulse |-> $past(run && cnt == CNT_MAX));

endmodule

bind split_read_timer split_read_timer_chk #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_chk (
  .bus_clk(bus_clk), .bus_rst(bus_rst), .tmr_clk(tmr_clk), .tmr_rst(tmr_rst),
  .bus_rd(bus_rd), .bus_half(bus_half), .bus_addr(bus_addr), .bus_rdata(bus_rdata),
  .wr_busy(wr_busy), .sh_data(sh_data), .latch_hi(latch_hi), .sh_kind(sh_kind),
  .cnt(t_cnt), .load(t_load), .run(t_run), .autorl(t_autorl), .apply(t_apply),
  .ovf_pulse(ovf_pulse)
);

// File: tb/split_read_timer_test.sv
module split_read_timer_test;

  logic        bclk = 1'b0, tclk = 1'b0;
  logic        brst = 1'b1, trst = 1'b1;
  logic        bus_wr = 1'b0, bus_rd = 1'b0, bus_half = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_rvalid, wr_busy, ovf_pulse;

  int checks = 0, errors = 0;
  int pulses = 0, wide = 0;
  logic prev_pulse = 1'b0;
  bit done = 1'b0;

  always #4 bclk = ~bclk;   // 125 MHz bus clock
  always #5 tclk = ~tclk;   // 100 MHz timer clock

  split_read_timer uut (
    .bus_clk(bclk), .bus_rst(brst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_half(bus_half), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid), .wr_busy(wr_busy),
    .tmr_clk(tclk), .tmr_rst(trst), .ovf_pulse(ovf_pulse)
  );

  always @(negedge tclk) begin
    if (ovf_pulse) pulses++;
    if (ovf_pulse && prev_pulse) wide++;
    prev_pulse = ovf_pulse;
  end

  function automatic logic [31:0] merge(input logic [31:0] cur, input logic hi_sel, input logic [15:0] d);
    return hi_sel ? {d, cur[15:0]} : {cur[31:16], d};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chk_ok(input string req, input bit ok, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bwrite(input logic [3:0] a, input logic h, input logic [31:0] d);
    @(negedge bclk);
    bus_wr = 1'b1; bus_addr = a; bus_half = h; bus_wdata = d;
    @(negedge bclk);
    bus_wr = 1'b0;
  endtask

  task automatic bread(input logic [3:0] a, input logic h, output logic [31:0] d);
    @(negedge bclk);
    bus_rd = 1'b1; bus_addr = a; bus_half = h;
    @(negedge bclk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic settle();
    @(negedge bclk);
    while (wr_busy) @(negedge bclk);
    repeat (40) @(negedge bclk);
  endtask

  task automatic report();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge bclk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
      report();
    end
  end

  initial begin
    logic [31:0] v, lo, hi, a, b, exp, cur;
    int base;
    void'($urandom(32'd2024));
    repeat (6) @(negedge bclk);
    brst = 1'b0; trst = 1'b0;
    repeat (40) @(negedge bclk);

    // R1 reset state
    chk("R1 busy", {31'b0, wr_busy}, 32'h0);
    chk("R1 ovf", {31'b0, ovf_pulse}, 32'h0);
    bread(4'h2, 1'b1, v); chk("R1 hi latch", v, 32'h0);
    bread(4'h0, 1'b0, v); chk("R1 counter", v, 32'h0);
    bread(4'h4, 1'b0, v); chk("R1 load", v, 32'h0);
    bread(4'h8, 1'b0, v); chk("R1 ctrl", v, 32'h0);

    // R5 R2 R3 R4 random values on a stopped counter
    for (int i = 0; i < 12; i++) begin
      v = $urandom;
      bwrite(4'h0, 1'b0, v); settle();
      bread(4'h0, 1'b0, a); chk("R5 R2 full write/read", a, v);
      bread(4'h0, 1'b1, lo); chk("R3 low half", lo, {16'h0, v[15:0]});
      bread(4'h2, 1'b1, hi); chk("R4 high half", hi, {16'h0, v[31:16]});
      cur = v;
      b = $urandom;
      exp = merge(cur, b[16], b[15:0]);
      bwrite(b[16] ? 4'h2 : 4'h0, 1'b1, {16'h0, b[15:0]}); settle();
      bread(4'h0, 1'b0, a); chk("R5 halfword write merge", a, exp);
    end

    // R4 held high half does not follow the live counter
    bwrite(4'h0, 1'b0, 32'h1111_2222); settle();
    bread(4'h0, 1'b1, lo);
    bwrite(4'h0, 1'b0, 32'h3333_4444); settle();
    bread(4'h2, 1'b1, hi); chk("R4 latch not live", hi, 32'h0000_1111);

    // R10 busy and dropped second write
    bwrite(4'h4, 1'b0, 32'h0000_AAAA);
    chk("R10 busy high", {31'b0, wr_busy}, 32'h1);
    bwrite(4'h4, 1'b0, 32'h0000_BBBB); settle();
    bread(4'h4, 1'b0, v); chk("R10 second write dropped", v, 32'h0000_AAAA);

    // R6 trigger reload on a stopped counter
    bwrite(4'h4, 1'b0, 32'hABCD_0000); settle();
    bwrite(4'hC, 1'b0, 32'h0); settle();
    bread(4'h0, 1'b0, v); chk("R6 trigger reload", v, 32'hABCD_0000);

    // R8 hold when stopped, rate when running
    bread(4'h0, 1'b0, a); repeat (50) @(negedge bclk); bread(4'h0, 1'b0, b);
    chk("R8 hold while stopped", b, a);
    bwrite(4'h0, 1'b0, 32'h0000_1000); settle();
    bwrite(4'h8, 1'b0, 32'h1); settle();
    bread(4'h0, 1'b0, a); repeat (198) @(negedge bclk); bread(4'h0, 1'b0, b);
    chk_ok("R8 increment rate", (b - a >= 145) && (b - a <= 175), b - a, 32'd160);

    // R2 R4 split read across a 16-bit carry stays coherent
    bwrite(4'h0, 1'b0, 32'h0000_FFE8); settle();
    bread(4'h0, 1'b0, a);
    bread(4'h0, 1'b1, lo);
    bread(4'h2, 1'b1, hi);
    bread(4'h0, 1'b0, b);
    v = {hi[15:0], lo[15:0]};
    chk_ok("R2 R4 coherent split read", (v >= a) && (v <= b), v, a);
    bwrite(4'h8, 1'b0, 32'h0); settle();

    // R7 R9 one-shot overflow
    bwrite(4'h0, 1'b0, 32'hFFFF_FFF0); settle();
    base = pulses;
    bwrite(4'h8, 1'b0, 32'h1); settle(); repeat (60) @(negedge bclk);
    bread(4'h0, 1'b0, v); chk("R7 one-shot clear", v, 32'h0);
    bread(4'h8, 1'b0, v); chk("R7 start cleared", v, 32'h0);
    chk("R9 one pulse", pulses - base, 32'd1);

    // R6 auto-reload overflow
    bwrite(4'h4, 1'b0, 32'h0000_0100); settle();
    bwrite(4'h0, 1'b0, 32'hFFFF_FFF8); settle();
    base = pulses;
    bwrite(4'h8, 1'b0, 32'h3); settle();
    bread(4'h0, 1'b0, v);
    chk_ok("R6 auto-reload", (v >= 32'h100) && (v < 32'h100 + 32'd120), v, 32'h100);
    bread(4'h8, 1'b0, a); chk("R6 still running", a, 32'h3);
    chk("R9 auto-reload pulse", pulses - base, 32'd1);
    bwrite(4'h8, 1'b0, 32'h0); settle();

    // R7 trigger reload swept across the one-shot overflow cycle
    bwrite(4'h4, 1'b0, 32'h0000_0055); settle();
    for (int d = 0; d < 16; d++) begin
      bwrite(4'h0, 1'b0, 32'hFFFF_FFF8); settle();
      base = pulses;
      bwrite(4'h8, 1'b0, 32'h1);
      @(negedge bclk); while (wr_busy) @(negedge bclk);
      repeat (d) @(negedge bclk);
      bwrite(4'hC, 1'b0, 32'h0); settle();
      bread(4'h0, 1'b0, v); bread(4'h8, 1'b0, a);
      chk_ok("R7 reload beats one-shot clear",
             (a == 32'h0 && v == 32'h55 && pulses - base == 1) ||
             (a == 32'h1 && v >= 32'h55 && v < 32'h55 + 32'd300 && pulses == base), v, 32'h55);
      bwrite(4'h8, 1'b0, 32'h0); settle();
    end

    chk("R9 pulse width", wide, 32'd0);
    done = 1'b1;
    report();
  end

endmodule